// File: doc/BRIEF.md
# Customer-Installation Alarm Bit Generator

This block emits a bit-serial alarm stream that lets a network tell a fault inside the network apart from one at the customer installation. Each pulse of the bit strobe advances the stream by one bit. A two-bit mode input picks one of three behaviours: idle, the AIS-CI alarm, or the RAI-CI alarm.

In AIS-CI mode the stream is all ones except for a 16-bit signature, which comes back every `AIS_PERIOD` bits. In RAI-CI mode the stream alternates between two phases. The first phase repeats a 16-bit message codeword for `MSG_BITS` bits. The second phase repeats a 16-bit signature codeword for `SIG_BITS` bits. The defaults, 3960 and 360 bits, give 0.99 s and 90 ms at a 4 kbit/s strobe rate. The stream is not line-coded, and no framing bits are inserted.

Top module: `ci_alarm_gen`

## Requirements
- R1: Mode 2'b01 selects AIS-CI and mode 2'b10 selects RAI-CI. Modes 2'b00 and 2'b11 are disabled. When a strobe arrives in a disabled mode, tx_bit becomes 1 and tx_valid becomes 0.
- R2: tx_bit and tx_valid change only in the clock cycle that follows a cycle where bit_en is high. They hold their values in every other cycle.
- R3: In AIS-CI mode the bit with index i is 1, except for i mod AIS_PERIOD equal to 8, 9 or 15. Those three bits are 0. This is the word 16'h7CFF, sent from the least significant bit first, at the start of each period. Index 0 is the first bit after the mode is selected.
- R4: The AIS-CI signature recurs every AIS_PERIOD bits (default 386), with no gap and no slip.
- R5: RAI-CI begins with a message phase of MSG_BITS bits. This phase repeats the word 16'h00FF, sent from the least significant bit first (eight ones, then eight zeros). The word restarts from its first bit at the start of the phase.
- R6: After the message phase comes a signature phase of SIG_BITS bits. This phase repeats the word 16'h3EFF, sent from the least significant bit first, and the word restarts at the start of the phase. The block then returns to the message phase, and the cycle repeats without end.
- R7: When a strobe arrives with a different enabled mode from the previous strobe, the output restarts at index 0 of the new sequence. After a strobe in a disabled mode, the next enabled strobe also starts at index 0.
- R8: Synchronous reset drives tx_bit to 1 and tx_valid to 0. After reset, the first enabled strobe begins at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe for each transmitted bit |
| mode | input | 2 | 01 selects AIS-CI, 10 selects RAI-CI, 00 and 11 are disabled |
| tx_bit | output | 1 | Serial alarm bit |
| tx_valid | output | 1 | High while an enabled alarm is being sent |

## Verification
Both outputs come from registers that load on the rising edge where bit_en is high. The result of a strobe is therefore due exactly one clock after that edge. Between strobes it must stay unchanged. The bench drives mode and bit_en on the falling edge and samples the outputs just after the following rising edge. It compares them with a model that counts the strobes since the current mode was entered, so each sample covers exactly one strobe. Cycles without a strobe are checked for unchanged outputs at the same sampling point.

// File: rtl/ci_alarm_gen.sv
module ci_alarm_gen #(
  parameter int AIS_PERIOD = 386,
  parameter int MSG_BITS   = 3960,
  parameter int SIG_BITS   = 360
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] mode,
  output logic       tx_bit,
  output logic       tx_valid
);
  localparam int MAXL = (AIS_PERIOD > MSG_BITS) ?
                        ((AIS_PERIOD > SIG_BITS) ? AIS_PERIOD : SIG_BITS) :
                        ((MSG_BITS > SIG_BITS) ? MSG_BITS : SIG_BITS);
  localparam int CW = (MAXL < 32) ? 6 : $clog2(MAXL + 1);
  localparam logic [15:0] AIS_WORD = 16'h7CFF;
  localparam logic [15:0] MSG_WORD = 16'h00FF;
  localparam logic [15:0] SIG_WORD = 16'h3EFF;

  logic [1:0]    mode_q;
  logic [CW-1:0] cnt;
  logic          sig_ph;
  logic          nxt_bit;

  wire is_ais  = (mode == 2'b01);
  wire is_rai  = (mode == 2'b10);
  wire on      = is_ais | is_rai;
  wire restart = (mode != mode_q);

  wire [CW-1:0] idx = restart ? '0 : cnt;
  wire          ph  = restart ? 1'b0 : sig_ph;
  wire [3:0]    w   = idx[3:0];

  wire [CW-1:0] limit = is_ais ? CW'(AIS_PERIOD - 1) :
                        (ph ? CW'(SIG_BITS - 1) : CW'(MSG_BITS - 1));
  wire wrap = (idx == limit);

  always_comb begin
    if (is_ais)   nxt_bit = (idx < CW'(16)) ? AIS_WORD[w] : 1'b1;
    else if (ph)  nxt_bit = SIG_WORD[w];
    else          nxt_bit = MSG_WORD[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 2'b00;
      cnt      <= '0;
      sig_ph   <= 1'b0;
      tx_bit   <= 1'b1;
      tx_valid <= 1'b0;
    end else if (bit_en) begin
      if (!on) begin
        mode_q   <= 2'b00;
        cnt      <= '0;
        sig_ph   <= 1'b0;
        tx_bit   <= 1'b1;
        tx_valid <= 1'b0;
      end else begin
        mode_q   <= mode;
        cnt      <= wrap ? '0 : idx + 1'b1;
        sig_ph   <= is_rai & (wrap ? ~ph : ph);
        tx_bit   <= nxt_bit;
        tx_valid <= 1'b1;
      end
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    bit_en && !on |=> tx_bit && !tx_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit) && $stable(tx_valid));

  p_ais_range_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01) |-> (int'(cnt) < AIS_PERIOD));

  p_sig_phase_r6: assert property (@(posedge clk) disable iff (rst)
    sig_ph |-> (mode_q == 2'b10) && (int'(cnt) < SIG_BITS));

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    bit_en && on && restart |=> tx_bit && tx_valid);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> tx_bit && !tx_valid);
endmodule

// File: tb/ci_alarm_gen_bench.sv
module ci_alarm_gen_bench;
  localparam int AP = 386;
  localparam int MB = 40;
  localparam int SB = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic tx_bit, tx_valid;

  int checks = 0;
  int fails = 0;
  int k = 0;
  logic [1:0] last = 2'b00;
  logic eb = 1'b1, ev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ci_alarm_gen #(.AIS_PERIOD(AP), .MSG_BITS(MB), .SIG_BITS(SB)) u_ci_alarm_gen (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mode(mode),
    .tx_bit(tx_bit), .tx_valid(tx_valid));

  function automatic logic ref_bit(input logic [1:0] m, input int n);
    int r;
    if (m == 2'b01) begin
      r = n % AP;
      return !(r == 8 || r == 9 || r == 15);
    end
    r = n % (MB + SB);
    if (r < MB) return 16'h00FF >> (r % 16);
    return 16'h3EFF >> ((r - MB) % 16);
  endfunction

  function automatic string ref_tag(input logic [1:0] m, input int n);
    int r;
    if (n == 0) return "R7";
    if (m == 2'b01) return (n >= AP) ? "R4" : "R3";
    r = n % (MB + SB);
    return (r < MB) ? "R5" : "R6";
  endfunction

  task automatic check(input string tag);
    checks++;
    if (tx_bit !== eb || tx_valid !== ev) begin
      fails++;
      $display("FAIL %s: bit=%b valid=%b expected bit=%b valid=%b", tag, tx_bit, tx_valid, eb, ev);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic en);
    string tag;
    @(negedge clk);
    mode = m;
    bit_en = en;
    @(posedge clk);
    #1;
    if (!en) tag = "R2";
    else if (m == 2'b00 || m == 2'b11) begin
      eb = 1'b1; ev = 1'b0; last = 2'b00; k = 0; tag = "R1";
    end else begin
      if (m != last) k = 0;
      eb = ref_bit(m, k);
      ev = 1'b1;
      tag = ref_tag(m, k);
      k++;
      last = m;
    end
    check(tag);
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    eb = 1'b1; ev = 1'b0; last = 2'b00; k = 0;
    check("R8");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: bit=%b valid=%b expected completion", tx_bit, tx_valid);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] rm;
    void'($urandom(32'd7531));
    repeat (2) @(posedge clk);
    do_reset;
    step(2'b00, 1'b1);
    step(2'b11, 1'b1);
    for (int i = 0; i < 2 * AP + 20; i++) step(2'b01, 1'b1);
    for (int i = 0; i < 3; i++) step(2'b01, 1'b0);
    for (int i = 0; i < 2 * (MB + SB) + 10; i++) step(2'b10, 1'b1);
    step(2'b01, 1'b1);
    for (int i = 0; i < 20; i++) step(2'b01, 1'b1);
    step(2'b11, 1'b1);
    step(2'b10, 1'b0);
    for (int i = 0; i < 20; i++) step(2'b10, 1'b1);
    do_reset;
    for (int i = 0; i < 20; i++) step(2'b10, 1'b1);
    do_reset;
    for (int i = 0; i < 20; i++) step(2'b01, 1'b1);
    rm = 2'b01;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 2) rm = 2'($urandom_range(3));
      step(rm, ($urandom_range(3) != 0));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule